// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Registers

This block keeps two banks of 64 control bits, one for peripheral resets and one for peripheral clock stopping. Each bank is split into a low word and a high word of 32 bits. Bit n lives in word n/32, at position n mod 32. Software reaches the words over a simple register bus that completes every access in one cycle. A write to a word's base offset sets the bits that are 1 in the data. A write to base+4 clears the bits that are 1 in the data. Bits written as 0 keep their value, so no read-modify-write is needed.

The block drives two 64-bit vectors. The reset vector follows the stored reset bits directly: a 1 holds that peripheral in reset. The clock-enable vector is the stored stop bits with a per-bit polarity applied. For every bit except one, a stored 1 stops the clock. For the inverted bit, which defaults to index 14, a stored 1 lets the clock run. After power-on every peripheral is held in reset and every clock is disabled.

Top module: `pcr_regfile`

## Requirements
- R1: After reset the reset words read 0xFFFFFFFF. The low stop word reads 0xFFFFBFFF (bit 14 clear) and the high stop word reads 0xFFFFFFFF. Every bit of `clk_en` and every bit of `periph_rst` is then 0 and 1 respectively.
- R2: The low reset word is at offset 0x040, the high reset word at 0x050, the low stop word at 0x080 and the high stop word at 0x090. A write to one of these offsets ORs the write data into that word.
- R3: A write to base+0x4 (0x044, 0x054, 0x084, 0x094) clears every bit of that word that is 1 in the write data.
- R4: Bits written as 0 through either alias keep their value, and the other three words are unchanged.
- R5: A read of a base offset returns the word's current state on `rd_data` in the same cycle, combinationally.
- R6: A read of a clear alias returns the same value as its base word.
- R7: `periph_rst[n]` equals reset bit n, where n = 32*word + position and the high word holds bits 32..63.
- R8: For n other than 14, `clk_en[n]` is the inverse of stop bit n.
- R9: `clk_en[14]` equals stop bit 14, so a 1 lets that clock run.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no state.
- R11: Both output vectors change in the cycle after the write edge, with no further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when no read is requested or the offset is unmapped |
| clk_en | output | 64 | Per-peripheral clock enable |
| periph_rst | output | 64 | Per-peripheral reset, 1 = held in reset |

## Verification
The assertions assume that the read and write strobes are never active in the same cycle. They also assume that the address is word aligned whenever a strobe is active. The bench drives one access at a time and uses only aligned offsets, so it stays within these assumptions. Its unmapped probes are aligned offsets that fall between the mapped ones and around them. The stimulus mixes sparse bit patterns, dense bit patterns and writes of all zeros. It targets bit 14 and both word boundaries, bits 31 and 32.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned N_WORDS = 2;
  localparam int unsigned N_BITS  = WORD_W * N_WORDS;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } op_e;

  typedef struct packed {
    logic [1:0] sel;   // {bank, word}: bank 0 reset, bank 1 stop
    logic       hit;
    logic       clr;
  } dec_t;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_BASE  = 12'h040,
  parameter logic [ADDR_W-1:0] STOP_BASE = 12'h080,
  parameter logic [ADDR_W-1:0] HI_STEP   = 12'h010
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] CLR_OFS = 12'h004;

  always_comb begin
    dec = '0;
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 2; w++) begin
        logic [ADDR_W-1:0] base;
        base = ((b == 0) ? RST_BASE : STOP_BASE) + ADDR_W'(w) * HI_STEP;
        if (addr == base) begin
          dec.hit = 1'b1;
          dec.sel = {1'(b), 1'(w)};
          dec.clr = 1'b0;
        end else if (addr == base + CLR_OFS) begin
          dec.hit = 1'b1;
          dec.sel = {1'(b), 1'(w)};
          dec.clr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcr_word.sv
module pcr_word
  import pcr_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    q_en  = (op != OP_NONE);
    q_nxt = q;
    unique case (op)
      OP_SET:  q_nxt = q | wdata;
      OP_CLR:  q_nxt = q & ~wdata;
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (q_en) q <= q_nxt;
  end

  // R4: a write of all zeros leaves the word unchanged
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE && wdata == '0) |=> $stable(q));
  // R3: a clear never sets a bit
  a_r3_clr_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> ((q & ~$past(q)) == '0));
  // R2: a set never clears a bit
  a_r2_set_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> ((~q & $past(q)) == '0));
endmodule

// File: rtl/pcr_regfile.sv
module pcr_regfile
  import pcr_pkg::*;
#(
  parameter int unsigned INV_BIT = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    rd_data,
  output logic [N_BITS-1:0]    clk_en,
  output logic [N_BITS-1:0]    periph_rst
);
  localparam logic [N_BITS-1:0] POL_MASK  = N_BITS'(1) << INV_BIT;
  localparam logic [N_BITS-1:0] STOP_INIT = ~POL_MASK;

  dec_t              dec;
  logic [WORD_W-1:0] words [4];

  pcr_decode u_dec (.addr(bus_addr), .dec(dec));

  for (genvar g = 0; g < 4; g++) begin : g_word
    localparam int unsigned WI = g % 2;
    localparam logic [WORD_W-1:0] RV =
      (g < 2) ? '1 : STOP_INIT[WI*WORD_W +: WORD_W];
    op_e op;
    always_comb begin
      op = OP_NONE;
      if (bus_wr && dec.hit && dec.sel == 2'(g))
        op = dec.clr ? OP_CLR : OP_SET;
    end
    pcr_word #(.RESET_VAL(RV)) u_word (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata), .q(words[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (bus_rd && dec.hit) rd_data = words[dec.sel];
  end

  // R7/R8/R9: per-bit polarity on the stop bank
  assign periph_rst = {words[1], words[0]};
  assign clk_en     = ~({words[3], words[2]} ^ POL_MASK);

  // input assumptions: no simultaneous strobes, aligned access
  a_in_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  // R10: unmapped write leaves both outputs unchanged
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !dec.hit) |=> ($stable(clk_en) && $stable(periph_rst)));
  // R10: unmapped read returns zero
  a_r10_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dec.hit) |-> (rd_data == '0));
  // R11: with no write, outputs hold
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> ($stable(clk_en) && $stable(periph_rst)));
  // R9: the inverted bit follows its stored value
  a_r9_inv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[INV_BIT] == words[2 + INV_BIT/WORD_W][INV_BIT%WORD_W]);
endmodule

// File: tb/pcr_regfile_test.sv
module pcr_regfile_test;
  localparam time TCLK = 10ns;

  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, rd_data;
  logic [63:0] clk_en, periph_rst;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m [4];

  pcr_regfile uut (.*);

  always #(TCLK/2) clk = ~clk;

  function automatic int idx(input logic [11:0] a);
    case (a)
      12'h040, 12'h044: return 0;
      12'h050, 12'h054: return 1;
      12'h080, 12'h084: return 2;
      12'h090, 12'h094: return 3;
      default:          return -1;
    endcase
  endfunction

  task automatic chk(input string r, input logic [63:0] act, exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp_v);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int i;
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    i = idx(a);
    if (i >= 0) m[i] = a[2] ? (m[i] & ~d) : (m[i] | d);
  endtask

  // driver: queue expected read value, monitor compares at the edge-free point
  task automatic rd(input logic [11:0] a, input string r);
    int i;
    @(negedge clk);
    i = idx(a);
    exp_q.push_back(i < 0 ? 32'h0 : m[i]);
    tag_q.push_back(r);
    bus_rd = 1; bus_addr = a;
    #(TCLK/4);
    -> mon_ev;
    @(negedge clk);
    bus_rd = 0;
  endtask

  event mon_ev;
  always @(mon_ev) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, {32'h0, rd_data}, {32'h0, e});
  end

  task automatic chk_out(input string r);
    logic [63:0] en;
    @(negedge clk);
    en = ~{m[3], m[2]};
    en[14] = m[2][14];
    chk({r, " clk_en"}, clk_en, en);
    chk({r, " periph_rst"}, periph_rst, {m[1], m[0]});
  endtask

  initial begin
    #(TCLK * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m[0] = '1; m[1] = '1; m[2] = 32'hFFFF_BFFF; m[3] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 clk_en", clk_en, 64'h0);
    chk("R1 periph_rst", periph_rst, '1);
    rd(12'h080, "R1 stop lo");
    rd(12'h090, "R1 stop hi");
    rd(12'h040, "R5 rst lo");
    // R3 clear rst bits, R7 mapping incl. word boundary
    wr(12'h044, 32'h8000_0001);
    wr(12'h054, 32'h0000_0001);
    chk_out("R7");
    rd(12'h044, "R6 clr alias");
    rd(12'h054, "R6 clr alias hi");
    // R2 set back
    wr(12'h040, 32'h0000_0001);
    rd(12'h040, "R2 set");
    // R4 zero write
    wr(12'h044, 32'h0);
    wr(12'h090, 32'h0);
    rd(12'h040, "R4 zero clr");
    chk_out("R4");
    // R8 run clocks by clearing stop bits
    wr(12'h084, 32'hA5A5_0F0F);
    wr(12'h094, 32'h8000_0001);
    chk_out("R8");
    // R9 inverted bit
    wr(12'h080, 32'h0000_4000);
    chk_out("R9 set14");
    wr(12'h084, 32'h0000_4000);
    chk_out("R9 clr14");
    // R11 timing: output must move right after the write edge
    @(negedge clk);
    bus_wr = 1; bus_addr = 12'h084; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_wr = 0; m[2] = m[2] & ~32'h2;
    chk("R11 clk_en bit1", {63'h0, clk_en[1]}, 64'h1);
    // R10 unmapped
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h098, 32'hFFFF_FFFF);
    wr(12'h088, 32'hFFFF_FFFF);
    chk_out("R10");
    rd(12'h048, "R10 rd");
    rd(12'h0A0, "R10 rd2");
    rd(12'h084, "R6 stop alias");
    rd(12'h094, "R5 stop hi");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule